// File: doc/BRIEF.md
# Programming Command Decoder

This block decodes the 15-bit programming words that a test access port delivers through its data register after each update. It splits each word into a command code and a data byte. It keeps the selected operation mode, a 16-bit address and a data byte. It raises write and read strobes toward a small behavioural memory model. That model holds an EEPROM array, one fuse byte, one lock byte and a fixed signature.

A write strobe is not a single opcode. It is recognised as a one-word low pulse on command bit 1 that immediately follows the hold command. After each accepted write, a busy counter models the nonvolatile write time. The host polls a completion flag in the 15-bit capture word until it reads 1.

All programming is gated by an enable flag. Only a fixed 16-bit key, loaded through the key port, sets that flag. The test access port state machine and real memory timing lie outside this block.

Top module: `prog_cmd_decoder`

## Requirements
- R1: An update word is taken when `upd_valid` is high. Bits [14:8] are the command and bits [7:0] are the data byte. After reset the enable flag is 0, `cap_word` is 0, the EEPROM bytes, the fuse byte and the lock byte all read 0xFF, and the mode is no-operation.
- R2: Command 7'b0100011 selects the mode from its data byte: 0x11 EEPROM write, 0x03 EEPROM read, 0x40 fuse write, 0x20 lock write, 0x04 fuse/lock read, 0x08 signature read. Any other value, including 0x00, selects no-operation.
- R3: Command 7'b0000111 loads the address high byte, 7'b0000011 loads the address low byte, and 7'b0010011 loads the data byte. The EEPROM index is the 16-bit address {high, low} modulo EE_DEPTH.
- R4: Command 7'b0110001 received directly after 7'b0110011 is a write strobe, and `wr_pulse` is high for exactly the next cycle. Command 7'b0110001 after any other command, and any strobe in a mode that is not a write mode, produce no pulse and no memory change.
- R5: In EEPROM write mode a strobe stores the data byte at the EEPROM index. In EEPROM read mode, command 7'b0110010 copies the byte at that index into `cap_word[7:0]`.
- R6: `cap_word[9]` is the completion flag. It reads 0 for WR_CYCLES cycles after an accepted write strobe and 1 otherwise while enabled. A write strobe that arrives while busy is ignored.
- R7: Loading key 16'hA370 sets the enable flag, loading 16'h0000 clears it, and any other key value leaves it unchanged.
- R8: While the enable flag is 0, every update word is ignored, `cap_word[9]` reads 0 and `wr_pulse` stays 0.
- R9: A fuse write stores the data byte as is. A lock write clears each lock bit whose data bit is 0 and leaves bits with data 1 unchanged. In fuse/lock read mode, 7'b0110010 returns the fuse byte for address low 0x00, the lock byte for 0x01, and 0xFF for any other value.
- R10: In signature read mode, 7'b0110010 returns SIG_BYTES[7:0], [15:8] or [23:16] for address low 0x00, 0x01 or 0x02, and 0xFF for any other value.
- R11: A 7'b0110010 read in a mode that is not a read mode leaves `cap_word[7:0]` unchanged. `cap_word[14:10]` and `cap_word[8]` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Loads key_word into the enable gate |
| key_word | input | 16 | Enable key value |
| upd_valid | input | 1 | Update strobe for upd_word |
| upd_word | input | 15 | Programming word: command [14:8], data [7:0] |
| cap_word | output | 15 | Capture word: completion flag [9], read byte [7:0] |
| prog_en | output | 1 | Programming enable flag |
| wr_pulse | output | 1 | One-cycle pulse per accepted write strobe |

## Verification
The strobe detector is driven with the full four-word write sequence, with a bit-1 low word that follows a data load, with strobes in read and no-operation modes, and with a second strobe while the first write is still busy. Together these separate a true falling-edge detector from one that decodes the low word alone or ignores the mode. Writes at addresses that differ only in the high byte show whether the high byte reaches the index. Two lock writes with overlapping zero patterns, then a write of all ones, separate a clear-only update from a plain store. The key port is tried with a near-miss key, the exact key and zero, and commands sent before enabling are read back afterwards to show they had no effect.

// File: rtl/prog_pkg.sv
package prog_pkg;

    localparam int CMD_W  = 7;
    localparam int DAT_W  = 8;
    localparam int WORD_W = CMD_W + DAT_W;

    localparam logic [CMD_W-1:0] OP_MODE = 7'b0100011;
    localparam logic [CMD_W-1:0] OP_AHI  = 7'b0000111;
    localparam logic [CMD_W-1:0] OP_ALO  = 7'b0000011;
    localparam logic [CMD_W-1:0] OP_DATA = 7'b0010011;
    localparam logic [CMD_W-1:0] OP_HOLD = 7'b0110011;
    localparam logic [CMD_W-1:0] OP_WLOW = 7'b0110001;
    localparam logic [CMD_W-1:0] OP_RLOW = 7'b0110010;

    typedef enum logic [2:0] {
        K_OTHER, K_MODE, K_AHI, K_ALO, K_DATA, K_HOLD, K_WLOW, K_RLOW
    } cmd_kind_t;

    typedef enum logic [2:0] {
        M_NOP, M_EE_WR, M_EE_RD, M_FUSE_WR, M_LOCK_WR, M_FL_RD, M_SIG_RD
    } mode_t;

    typedef struct packed {
        cmd_kind_t        kind;
        logic [CMD_W-1:0] op;
        logic [DAT_W-1:0] data;
    } instr_t;

    function automatic cmd_kind_t classify(input logic [CMD_W-1:0] op);
        case (op)
            OP_MODE: return K_MODE;
            OP_AHI:  return K_AHI;
            OP_ALO:  return K_ALO;
            OP_DATA: return K_DATA;
            OP_HOLD: return K_HOLD;
            OP_WLOW: return K_WLOW;
            OP_RLOW: return K_RLOW;
            default: return K_OTHER;
        endcase
    endfunction

    function automatic mode_t mode_of(input logic [DAT_W-1:0] d);
        case (d)
            8'h11:   return M_EE_WR;
            8'h03:   return M_EE_RD;
            8'h40:   return M_FUSE_WR;
            8'h20:   return M_LOCK_WR;
            8'h04:   return M_FL_RD;
            8'h08:   return M_SIG_RD;
            default: return M_NOP;
        endcase
    endfunction

    function automatic logic is_write_mode(input mode_t m);
        return (m == M_EE_WR) || (m == M_FUSE_WR) || (m == M_LOCK_WR);
    endfunction

endpackage

// File: rtl/cmd_split.sv
module cmd_split
    import prog_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output instr_t            ins
);
    always_comb begin
        ins.op   = word[WORD_W-1:DAT_W];
        ins.data = word[DAT_W-1:0];
        ins.kind = classify(word[WORD_W-1:DAT_W]);
    end
endmodule

// File: rtl/key_gate.sv
module key_gate #(
    parameter int          KEY_W = 16,
    parameter logic [15:0] KEY   = 16'hA370
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_load,
    input  logic [KEY_W-1:0] key_word,
    output logic             en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else if (key_load) begin
            if (key_word == KEY_W'(KEY)) en <= 1'b1;
            else if (key_word == '0)     en <= 1'b0;
        end
    end

    AST_EN_RISE_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> $past(key_load && key_word == KEY_W'(KEY))); // R7
    AST_EN_FALL_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |-> $past(key_load && key_word == '0)); // R7
endmodule

// File: rtl/prog_stub.sv
module prog_stub
    import prog_pkg::*;
#(
    parameter int          EE_DEPTH  = 512,
    parameter int          WR_CYCLES = 16,
    parameter logic [23:0] SIG_BYTES = 24'h1E9702
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              rd_req,
    input  mode_t             mode,
    input  logic [15:0]       addr,
    input  logic [DAT_W-1:0]  wdata,
    output logic              busy,
    output logic              wr_pulse,
    output logic [DAT_W-1:0]  rd_byte
);
    localparam int AW = (EE_DEPTH > 1) ? $clog2(EE_DEPTH) : 1;
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [DAT_W-1:0] ee_mem [EE_DEPTH];
    logic [DAT_W-1:0] fuse_q, lock_q;
    logic [CW-1:0]    cnt_q;
    logic [AW-1:0]    ee_idx;
    logic             wr_ok;
    logic [DAT_W-1:0] rd_val;
    logic             rd_ok;

    assign ee_idx = AW'(addr % EE_DEPTH);
    assign busy   = (cnt_q != '0);
    assign wr_ok  = wr_req && !busy && is_write_mode(mode);

    always_comb begin
        rd_ok  = 1'b1;
        rd_val = 8'hFF;
        case (mode)
            M_EE_RD: rd_val = ee_mem[ee_idx];
            M_FL_RD: begin
                if (addr[7:0] == 8'h00)      rd_val = fuse_q;
                else if (addr[7:0] == 8'h01) rd_val = lock_q;
            end
            M_SIG_RD: begin
                if (addr[7:0] == 8'h00)      rd_val = SIG_BYTES[7:0];
                else if (addr[7:0] == 8'h01) rd_val = SIG_BYTES[15:8];
                else if (addr[7:0] == 8'h02) rd_val = SIG_BYTES[23:16];
            end
            default: rd_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            wr_pulse <= 1'b0;
        end else begin
            wr_pulse <= wr_ok;
            if (wr_ok)     cnt_q <= CW'(WR_CYCLES);
            else if (busy) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fuse_q  <= 8'hFF;
            lock_q  <= 8'hFF;
            rd_byte <= '0;
        end else begin
            if (wr_ok && mode == M_FUSE_WR) fuse_q <= wdata;
            if (wr_ok && mode == M_LOCK_WR) lock_q <= lock_q & wdata;
            if (rd_req && rd_ok)            rd_byte <= rd_val;
        end
    end

    generate
        for (genvar g = 0; g < EE_DEPTH; g++) begin : g_ee
            always_ff @(posedge clk) begin
                if (rst)                                       ee_mem[g] <= 8'hFF;
                else if (wr_ok && mode == M_EE_WR && ee_idx == AW'(g)) ee_mem[g] <= wdata;
            end
        end
    endgenerate

    initial begin
        AST_WR_TIME_NONZERO: assert (WR_CYCLES >= 1); // R6
    end

    AST_BUSY_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> busy); // R6
    AST_NO_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wr_req && busy) |=> !wr_pulse); // R6
    AST_LOCK_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lock_q & ~$past(lock_q)) == 8'h00)); // R9
endmodule

// File: rtl/prog_cmd_decoder.sv
module prog_cmd_decoder
    import prog_pkg::*;
#(
    parameter int          EE_DEPTH   = 512,
    parameter int          WR_CYCLES  = 16,
    parameter logic [15:0] UNLOCK_KEY = 16'hA370,
    parameter logic [23:0] SIG_BYTES  = 24'h1E9702
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        key_load,
    input  logic [15:0] key_word,
    input  logic        upd_valid,
    input  logic [14:0] upd_word,
    output logic [14:0] cap_word,
    output logic        prog_en,
    output logic        wr_pulse
);
    instr_t           ins;
    mode_t            mode_q;
    logic [7:0]       addr_hi_q, addr_lo_q, data_q;
    logic [CMD_W-1:0] prev_op_q;
    logic             acc, wr_req, rd_req, busy;
    logic [7:0]       rd_byte;

    cmd_split u_split (.word(upd_word), .ins(ins));

    key_gate #(.KEY_W(16), .KEY(UNLOCK_KEY)) u_key (
        .clk(clk), .rst(rst), .key_load(key_load), .key_word(key_word), .en(prog_en)
    );

    assign acc    = upd_valid && prog_en;
    assign wr_req = acc && (ins.kind == K_WLOW) && (prev_op_q == OP_HOLD);
    assign rd_req = acc && (ins.kind == K_RLOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= M_NOP;
            addr_hi_q <= '0;
            addr_lo_q <= '0;
            data_q    <= '0;
            prev_op_q <= '0;
        end else if (acc) begin
            prev_op_q <= ins.op;
            case (ins.kind)
                K_MODE:  mode_q    <= mode_of(ins.data);
                K_AHI:   addr_hi_q <= ins.data;
                K_ALO:   addr_lo_q <= ins.data;
                K_DATA:  data_q    <= ins.data;
                default: ;
            endcase
        end
    end

    prog_stub #(.EE_DEPTH(EE_DEPTH), .WR_CYCLES(WR_CYCLES), .SIG_BYTES(SIG_BYTES)) u_stub (
        .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req), .mode(mode_q),
        .addr({addr_hi_q, addr_lo_q}), .wdata(data_q),
        .busy(busy), .wr_pulse(wr_pulse), .rd_byte(rd_byte)
    );

    assign cap_word = {5'b0, prog_en && !busy, 1'b0, rd_byte};

    AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(prog_en)); // R8
    AST_IGNORED_OFF: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !prog_en) |=> ($stable(mode_q) && $stable(data_q) && $stable(addr_lo_q))); // R8
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse); // R4
endmodule

// File: tb/test_prog_cmd_decoder.sv
module test_prog_cmd_decoder;
    localparam int WR = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_load = 1'b0;
    logic [15:0] key_word = '0;
    logic        upd_valid = 1'b0;
    logic [14:0] upd_word = '0;
    logic [14:0] cap_word;
    logic        prog_en, wr_pulse;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prog_cmd_decoder #(.EE_DEPTH(512), .WR_CYCLES(WR), .UNLOCK_KEY(16'hA370),
                       .SIG_BYTES(24'h1E9702)) i_prog_cmd_decoder (
        .clk(clk), .rst(rst), .key_load(key_load), .key_word(key_word),
        .upd_valid(upd_valid), .upd_word(upd_word),
        .cap_word(cap_word), .prog_en(prog_en), .wr_pulse(wr_pulse)
    );

    localparam logic [6:0] C_MODE = 7'b0100011, C_AHI = 7'b0000111, C_ALO = 7'b0000011,
                           C_DATA = 7'b0010011, C_HOLD = 7'b0110011, C_WLOW = 7'b0110001,
                           C_RLOW = 7'b0110010;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [6:0] op, input logic [7:0] d);
        upd_valid = 1'b1;
        upd_word  = {op, d};
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic load_key(input logic [15:0] k);
        key_load = 1'b1;
        key_word = k;
        @(negedge clk);
        key_load = 1'b0;
    endtask

    task automatic wr_seq();
        send(C_HOLD, 8'h00);
        send(C_WLOW, 8'h00);
        send(C_HOLD, 8'h00);
        send(C_HOLD, 8'h00);
    endtask

    task automatic settle();
        repeat (WR + 2) @(negedge clk);
    endtask

    task automatic read_at(input logic [7:0] m, input logic [7:0] lo, output logic [7:0] v);
        send(C_MODE, m);
        send(C_ALO, lo);
        send(C_RLOW, 8'h00);
        v = cap_word[7:0];
    endtask

    task automatic t_reset();
        check(cap_word == 15'h0, "R1 reset capture", cap_word, 0);
        check(prog_en == 1'b0, "R1 reset enable", prog_en, 0);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        bit seen = 1'b0;
        send(C_MODE, 8'h11);
        send(C_ALO, 8'h03);
        send(C_DATA, 8'h5A);
        send(C_HOLD, 8'h00);
        send(C_WLOW, 8'h00);
        seen = wr_pulse;
        check(!seen, "R8 no pulse when disabled", seen, 0);
        check(cap_word[9] == 1'b0, "R8 status zero when disabled", cap_word[9], 0);
        load_key(16'hA371);
        check(prog_en == 1'b0, "R7 near-miss key", prog_en, 0);
        load_key(16'hA370);
        check(prog_en == 1'b1, "R7 exact key enables", prog_en, 1);
        check(cap_word[9] == 1'b1, "R6 idle complete flag", cap_word[9], 1);
        read_at(8'h03, 8'h03, v);
        check(v == 8'hFF, "R8 disabled write had no effect", v, 8'hFF);
        check(cap_word[14:10] == 5'h0 && cap_word[8] == 1'b0, "R11 spare capture bits", cap_word, 0);
    endtask

    task automatic t_ee_hi();
        logic [7:0] v;
        send(C_MODE, 8'h11);
        send(C_AHI, 8'h01);
        send(C_ALO, 8'h05);
        send(C_DATA, 8'h11);
        wr_seq();
        settle();
        send(C_AHI, 8'h00);
        send(C_DATA, 8'h22);
        wr_seq();
        settle();
        send(C_AHI, 8'h01);
        read_at(8'h03, 8'h05, v);
        check(v == 8'h11, "R3 R5 high byte 1 read", v, 8'h11);
        send(C_AHI, 8'h00);
        read_at(8'h03, 8'h05, v);
        check(v == 8'h22, "R3 R5 high byte 0 read", v, 8'h22);
        send(C_AHI, 8'h02);
        read_at(8'h03, 8'h05, v);
        check(v == 8'h22, "R3 index modulo depth", v, 8'h22);
        send(C_AHI, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        send(C_MODE, 8'h11);
        send(C_ALO, 8'h20);
        send(C_DATA, 8'hA1);
        send(C_HOLD, 8'h00);
        send(C_WLOW, 8'h00);
        check(wr_pulse == 1'b1, "R4 pulse after sequence", wr_pulse, 1);
        check(cap_word[9] == 1'b0, "R6 busy right after strobe", cap_word[9], 0);
        send(C_ALO, 8'h21);
        check(wr_pulse == 1'b0, "R4 pulse one cycle", wr_pulse, 0);
        send(C_DATA, 8'hB2);
        send(C_HOLD, 8'h00);
        send(C_WLOW, 8'h00);
        check(wr_pulse == 1'b0, "R6 strobe while busy ignored", wr_pulse, 0);
        repeat (WR - 5) @(negedge clk);
        check(cap_word[9] == 1'b0, "R6 still busy last cycle", cap_word[9], 0);
        @(negedge clk);
        check(cap_word[9] == 1'b1, "R6 complete after window", cap_word[9], 1);
        read_at(8'h03, 8'h20, v);
        check(v == 8'hA1, "R5 first write stored", v, 8'hA1);
        read_at(8'h03, 8'h21, v);
        check(v == 8'hFF, "R6 busy write dropped", v, 8'hFF);
    endtask

    task automatic t_order();
        logic [7:0] v;
        send(C_MODE, 8'h11);
        send(C_ALO, 8'h30);
        send(C_DATA, 8'h77);
        send(C_WLOW, 8'h00);
        check(wr_pulse == 1'b0, "R4 low word without hold", wr_pulse, 0);
        send(C_MODE, 8'h03);
        send(C_HOLD, 8'h00);
        send(C_WLOW, 8'h00);
        check(wr_pulse == 1'b0, "R4 strobe in read mode", wr_pulse, 0);
        send(C_MODE, 8'h55);
        send(C_HOLD, 8'h00);
        send(C_WLOW, 8'h00);
        check(wr_pulse == 1'b0, "R2 unknown mode is no-op", wr_pulse, 0);
        read_at(8'h03, 8'h30, v);
        check(v == 8'hFF, "R4 no memory change", v, 8'hFF);
        send(C_MODE, 8'h00);
        send(C_RLOW, 8'h00);
        check(cap_word[7:0] == 8'hFF, "R11 read in no-op keeps byte", cap_word[7:0], 8'hFF);
    endtask

    task automatic t_fuse_lock();
        logic [7:0] v;
        send(C_MODE, 8'h40);
        send(C_DATA, 8'h3C);
        wr_seq();
        settle();
        send(C_MODE, 8'h20);
        send(C_DATA, 8'hF3);
        wr_seq();
        settle();
        send(C_DATA, 8'hFC);
        wr_seq();
        settle();
        send(C_DATA, 8'hFF);
        wr_seq();
        settle();
        read_at(8'h04, 8'h00, v);
        check(v == 8'h3C, "R9 fuse stored as is", v, 8'h3C);
        read_at(8'h04, 8'h01, v);
        check(v == 8'hF0, "R9 lock clear-only", v, 8'hF0);
        read_at(8'h04, 8'h07, v);
        check(v == 8'hFF, "R9 other fuse/lock address", v, 8'hFF);
    endtask

    task automatic t_sig();
        logic [7:0] v;
        read_at(8'h08, 8'h00, v);
        check(v == 8'h02, "R10 signature 0", v, 8'h02);
        read_at(8'h08, 8'h01, v);
        check(v == 8'h97, "R10 signature 1", v, 8'h97);
        read_at(8'h08, 8'h02, v);
        check(v == 8'h1E, "R10 signature 2", v, 8'h1E);
        read_at(8'h08, 8'h03, v);
        check(v == 8'hFF, "R10 signature out of range", v, 8'hFF);
    endtask

    task automatic t_disable();
        load_key(16'h1234);
        check(prog_en == 1'b1, "R7 other key keeps enable", prog_en, 1);
        load_key(16'h0000);
        check(prog_en == 1'b0, "R7 zero key disables", prog_en, 0);
        check(cap_word[9] == 1'b0, "R8 status after disable", cap_word[9], 0);
        send(C_MODE, 8'h08);
        send(C_ALO, 8'h01);
        send(C_RLOW, 8'h00);
        check(cap_word[7:0] == 8'hFF, "R8 read ignored when disabled", cap_word[7:0], 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_ee_hi();
        t_busy();
        t_order();
        t_fuse_lock();
        t_sig();
        t_disable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule